// File: doc/BRIEF.md
# UART Receive Error Status Unit

This block holds the receive-side error status of one serial channel. Characters from a serial receiver arrive on a push interface, each carrying three tags: parity error, framing error and received break. They are stored in a small holding FIFO that the host drains through a pop strobe. The host reads a four-bit error status, and it writes command nibbles that clear the error status or the break-change interrupt.

Two error-reporting modes are provided. In block mode the break, framing and parity status bits are sticky. Each one accumulates the matching tag of every character accepted into the FIFO, until the host clears them with a command. In character mode the same three bits follow only the character at the head of the FIFO. The overrun bit is sticky in both modes. A separate break-change flag is raised on every transition of the receiver's break-detect input.

Top module: `rx_err_status`

## Requirements
- R1: After reset `stat_err` is 0, `brk_chg_irq` is 0 and `rx_ready` is 0 (FIFO empty).
- R2: The FIFO holds DEPTH (default 3) characters in arrival order. `head_data` shows the oldest character and `rx_ready` is high while the FIFO is not empty. A `pop` while the FIFO is empty has no effect.
- R3: A push while the FIFO is full and `pop` is low discards the incoming character, keeps the stored characters unchanged, and sets the overrun bit `stat_err[0]` one cycle later.
- R4: The overrun bit stays set in both modes, across pops and across any command other than the error-clear nibble 4'b0100.
- R5: With `char_mode` = 0, `stat_err[3]` (break), `stat_err[2]` (framing) and `stat_err[1]` (parity) are the OR of the `push_rb`, `push_fe` and `push_pe` tags of every character accepted since the last clear. Popping characters does not change them.
- R6: With `char_mode` = 1, `stat_err[3:1]` equals the {rb, fe, pe} tags of the character at the FIFO head, and is 0 while the FIFO is empty.
- R7: A write of nibble 4'b0100 (`cmd_we` high) clears the sticky break, framing, parity and overrun flags on the next edge.
- R8: When a set event (an accepted tagged push, an overrun, or a break-detect edge) falls in the same cycle as the command that clears that flag, the flag ends up set.
- R9: Every rising or falling edge of `brk_det` sets `brk_chg_irq`. A write of nibble 4'b0101 clears it. Other nibbles affect neither it nor the error flags.
- R10: A push together with a pop while the FIFO is full is accepted: the oldest character leaves, the new one enters at the tail, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command nibble write strobe |
| cmd_nib | input | 4 | Command code (upper nibble of the host command) |
| push_valid | input | 1 | Receiver delivers a character this cycle |
| push_data | input | DW | Received character |
| push_pe | input | 1 | Parity-error tag of the character |
| push_fe | input | 1 | Framing-error tag of the character |
| push_rb | input | 1 | Received-break tag of the character |
| pop | input | 1 | Host read removes the head character |
| char_mode | input | 1 | 0 selects block error mode, 1 selects character error mode |
| brk_det | input | 1 | Receiver break-detect level |
| stat_err | output | 4 | {break, framing, parity, overrun} status |
| brk_chg_irq | output | 1 | Break-change interrupt flag |
| rx_ready | output | 1 | FIFO holds at least one character |
| head_data | output | DW | Character at the FIFO head |

## Verification
Two kinds of collision matter here. A set event can land in the same cycle as its clearing command, and a push can coincide with a pop while the FIFO is full. The bench provokes the first by issuing nibble 4'b0100 together with a tagged push, and again together with an overflowing push. It also issues nibble 4'b0101 on the cycle where `brk_det` toggles. It provokes the second by pushing and popping at once on a full FIFO. A reference model that follows the requirements judges each cycle: the flag must survive the clear, and the swap must be accepted with no overrun, with the data order confirmed by the later reads.

// File: rtl/rx_err_status.sv
module rx_err_status #(
  parameter int DEPTH = 3,
  parameter int DW = 8,
  parameter logic [3:0] CMD_CLR_ERR = 4'b0100,
  parameter logic [3:0] CMD_CLR_BRK = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [3:0]    cmd_nib,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          push_pe,
  input  logic          push_fe,
  input  logic          push_rb,
  input  logic          pop,
  input  logic          char_mode,
  input  logic          brk_det,
  output logic [3:0]    stat_err,
  output logic          brk_chg_irq,
  output logic          rx_ready,
  output logic [DW-1:0] head_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [2:0]    blk;
  logic          ovr, brk_q, irq;

  wire full    = (cnt == CW'(DEPTH));
  wire empty   = (cnt == '0);
  wire do_pop  = pop && !empty;
  wire do_push = push_valid && (!full || pop);
  wire ovf     = push_valid && full && !pop;
  wire clr_err = cmd_we && (cmd_nib == CMD_CLR_ERR);
  wire clr_brk = cmd_we && (cmd_nib == CMD_CLR_BRK);
  wire [2:0] tags_in = {push_rb, push_fe, push_pe};
  wire [EW-1:0] head = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {tags_in, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk <= '0;
      ovr <= 1'b0;
    end else begin
      blk <= (clr_err ? 3'b000 : blk) | (do_push ? tags_in : 3'b000);
      ovr <= (ovr && !clr_err) || ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      brk_q <= brk_det;
      if (brk_det != brk_q) irq <= 1'b1;
      else if (clr_brk)     irq <= 1'b0;
    end
  end

  wire [2:0] head_tags = empty ? 3'b000 : head[EW-1:DW];

  assign stat_err    = {char_mode ? head_tags : blk, ovr};
  assign brk_chg_irq = irq;
  assign rx_ready    = !empty;
  assign head_data   = head[DW-1:0];

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push_valid) |=> (cnt == '0));
  assert_ovf_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (full && ovr && $stable(rp)));
  assert_oe_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_err) |=> ovr);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !push_valid) |=> (stat_err[0] == 1'b0 && blk == 3'b000));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && ovf) |=> stat_err[0]);
  assert_brk_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det != brk_q) |=> brk_chg_irq);
  assert_brk_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_brk && brk_det == brk_q) |=> !brk_chg_irq);
  assert_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop && full && !ovr && !clr_err) |=> (full && !ovr));
endmodule

// File: tb/rx_err_status_tb.sv
module rx_err_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, push_valid = 0, push_pe = 0, push_fe = 0, push_rb = 0;
  logic pop = 0, char_mode = 0, brk_det = 0;
  logic [3:0] cmd_nib = 0;
  logic [7:0] push_data = 0;
  logic [3:0] stat_err;
  logic brk_chg_irq, rx_ready;
  logic [7:0] head_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_status #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_nib(cmd_nib),
    .push_valid(push_valid), .push_data(push_data), .push_pe(push_pe),
    .push_fe(push_fe), .push_rb(push_rb), .pop(pop), .char_mode(char_mode),
    .brk_det(brk_det), .stat_err(stat_err), .brk_chg_irq(brk_chg_irq),
    .rx_ready(rx_ready), .head_data(head_data));

  int checks = 0, fails = 0;
  logic [10:0] mq[$];
  logic [2:0] m_blk = 0;
  logic m_ovr = 0, m_irq = 0, m_brk = 0;
  logic [7:0] exp_q[$], got_q[$];
  string rd_tag[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0 && got_q.size() > 0)
      chk(rd_tag.pop_front(), "read data", got_q.pop_front(), exp_q.pop_front());
  end

  task automatic compare(input string tag);
    logic [2:0] ht;
    ht = (mq.size() > 0) ? mq[0][10:8] : 3'b000;
    chk(tag, "stat_err", stat_err, {char_mode ? ht : m_blk, m_ovr});
    chk(tag, "brk_chg_irq", brk_chg_irq, m_irq);
    chk(tag, "rx_ready", rx_ready, mq.size() > 0);
    if (mq.size() > 0) chk(tag, "head_data", head_data, mq[0][7:0]);
  endtask

  // t = {rb, fe, pe}
  task automatic cyc(input string tag, input logic pv, input logic [7:0] d,
                     input logic [2:0] t, input logic pp, input logic we,
                     input logic [3:0] nib);
    logic full, acc, ovf, popok;
    push_valid = pv; push_data = d; {push_rb, push_fe, push_pe} = t;
    pop = pp; cmd_we = we; cmd_nib = nib;
    full  = (mq.size() == DEPTH);
    popok = pp && mq.size() > 0;
    acc   = pv && (!full || pp);
    ovf   = pv && full && !pp;
    if (popok) begin
      got_q.push_back(head_data);
      exp_q.push_back(mq[0][7:0]);
      rd_tag.push_back(tag);
    end
    @(posedge clk);
    if (we && nib == 4'b0100) begin m_blk = 0; m_ovr = 0; end
    if (acc) m_blk = m_blk | t;
    if (ovf) m_ovr = 1;
    if (popok) void'(mq.pop_front());
    if (acc) mq.push_back({t, d});
    if (we && nib == 4'b0101) m_irq = 0;
    if (brk_det != m_brk) m_irq = 1;
    m_brk = brk_det;
    @(negedge clk);
    push_valid = 0; pop = 0; cmd_we = 0;
    compare(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    // R2 / R5: fill in block mode with mixed tags
    cyc("R5", 1, 8'hA1, 3'b001, 0, 0, 0);
    cyc("R5", 1, 8'hB2, 3'b000, 0, 0, 0);
    cyc("R5", 1, 8'hC3, 3'b010, 0, 0, 0);
    // R3: overflow discards D4
    cyc("R3", 1, 8'hD4, 3'b100, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 1, 4'b0011);
    // R2 order, R5 flags persist over pops
    cyc("R2", 0, 0, 0, 1, 0, 0);
    cyc("R2", 0, 0, 0, 1, 0, 0);
    cyc("R2", 0, 0, 0, 1, 0, 0);
    cyc("R2", 0, 0, 0, 1, 0, 0);
    // R7 clear
    cyc("R7", 0, 0, 0, 0, 1, 4'b0100);
    // R6 character mode
    char_mode = 1;
    cyc("R6", 0, 0, 0, 0, 0, 0);
    cyc("R6", 1, 8'h11, 3'b100, 0, 0, 0);
    cyc("R6", 1, 8'h22, 3'b011, 0, 0, 0);
    cyc("R6", 1, 8'h33, 3'b000, 0, 0, 0);
    cyc("R4", 1, 8'h44, 3'b111, 0, 0, 0);
    cyc("R6", 0, 0, 0, 1, 0, 0);
    cyc("R6", 0, 0, 0, 1, 0, 0);
    cyc("R4", 0, 0, 0, 1, 0, 0);
    cyc("R4", 0, 0, 0, 0, 1, 4'b0101);
    // R8 set wins over clear
    char_mode = 0;
    cyc("R7", 0, 0, 0, 0, 1, 4'b0100);
    cyc("R8", 1, 8'h55, 3'b010, 0, 1, 4'b0100);
    cyc("R8", 1, 8'h66, 3'b000, 0, 0, 0);
    cyc("R8", 1, 8'h77, 3'b000, 0, 0, 0);
    cyc("R8", 1, 8'h88, 3'b001, 0, 1, 4'b0100);
    // R10 push with pop while full
    cyc("R7", 0, 0, 0, 0, 1, 4'b0100);
    cyc("R10", 1, 8'h99, 3'b100, 1, 0, 0);
    cyc("R10", 0, 0, 0, 1, 0, 0);
    cyc("R10", 0, 0, 0, 1, 0, 0);
    cyc("R10", 0, 0, 0, 1, 0, 0);
    // R9 break change
    brk_det = 1;
    cyc("R9", 0, 0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 1, 4'b0100);
    cyc("R9", 0, 0, 0, 0, 1, 4'b0101);
    brk_det = 0;
    cyc("R9", 0, 0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 1, 4'b0101);
    brk_det = 1;
    cyc("R8", 0, 0, 0, 0, 1, 4'b0101);
    cyc("R8", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule